// File: doc/BRIEF.md
# Seconds Countdown Alarm with Interrupt and Wakeup

This block counts a programmed number of seconds down to zero. Software writes the remaining seconds into a 32-bit count register and sets a run bit; from then on every one-cycle `tick` pulse (one per second) lowers the count by one. When the count steps from 1 to 0 the block latches a sticky pending flag. That flag drives an interrupt line when the interrupt enable is set, and a wakeup line when the wakeup option is set.

Control uses five word addresses on a simple single-cycle write port and a combinational read port. The run bit, the interrupt enable, the pending flag and the wakeup option each sit alone in bit 0 of their own register. Software clears the pending flag by writing 1 to it. To reprogram the alarm safely, software first writes 0 to the count and clears the run bit. It then loads the new count and sets the run bit again.

Top module: `cd_alarm`

## Requirements
- R1: After reset the count is 0, the run, interrupt-enable, pending and wakeup bits are 0, and `irq` and `wake` are low.
- R2: A write to address 0 loads all 32 bits of `wr_data` into the count, visible on read address 0 from the next cycle. A count write in the same cycle as a tick takes the written value, with no decrement.
- R3: A tick decrements the count by one only when the run bit (address 1, bit 0) is 1 and the count is nonzero. With the run bit at 0 the count holds.
- R4: A tick that moves the count from 1 to 0 sets the pending flag (address 3, bit 0) on the same clock edge. The count then stays at 0 on later ticks.
- R5: Ticks on a count of 0 with the run bit set never set the pending flag.
- R6: Writing address 3 with bit 0 = 1 clears the pending flag. Writing it with bit 0 = 0 leaves the flag unchanged.
- R7: When a clear write and an expiry fall in the same cycle, the pending flag ends up set.
- R8: `irq` is high exactly when the pending flag and the interrupt-enable bit (address 2, bit 0) are both 1.
- R9: `wake` is high exactly when the pending flag and the wakeup bit (address 4, bit 0) are both 1.
- R10: The single-bit registers at addresses 1 to 4 take `wr_data[0]` on a write and read back with bits 31:1 as 0. Addresses 5 to 7 read as 0 and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse per second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read word address |
| rd_data | output | 32 | Read data for `rd_addr` |
| irq | output | 1 | Interrupt: pending AND interrupt enable |
| wake | output | 1 | Wakeup: pending AND wakeup option |

## Verification
Directed cases first load a short count and run it to expiry. This separates the 1-to-0 step from ticks that land on 0 or arrive while stopped. A full 32-bit load shows the decrement works across the whole width. Collision cases put a count write on the same cycle as a tick, and a clear write on the same cycle as an expiry, to show which side wins each time. Seeded random traffic then mixes short counts, random register writes and random ticks, and compares every register, `irq` and `wake` against a cycle model after each cycle.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
    localparam int ALM_ADDR_W = 3;

    localparam logic [ALM_ADDR_W-1:0] ADR_COUNT = 3'd0;
    localparam logic [ALM_ADDR_W-1:0] ADR_RUN   = 3'd1;
    localparam logic [ALM_ADDR_W-1:0] ADR_IRQEN = 3'd2;
    localparam logic [ALM_ADDR_W-1:0] ADR_PEND  = 3'd3;
    localparam logic [ALM_ADDR_W-1:0] ADR_WAKE  = 3'd4;

    typedef struct packed {
        logic run;
        logic irq_en;
        logic pend;
        logic wake_en;
    } ctrl_t;
endpackage

// File: rtl/cd_counter.sv
module cd_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       step;

    always_comb begin
        st_d   = st_q;
        step   = run && tick && (st_q.cnt != '0);
        expire = step && !ld && (st_q.cnt == ONE);
        if (ld) begin
            st_d.cnt = ld_val;
        end else if (step) begin
            st_d.cnt = st_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;
endmodule

// File: rtl/cd_ctrl.sv
module cd_ctrl
    import alarm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ALM_ADDR_W-1:0] wr_addr,
    input  logic                  wr_bit,
    input  logic                  expire,
    output ctrl_t                 ctrl
);
    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            unique case (wr_addr)
                ADR_RUN:   ctl_d.run     = wr_bit;
                ADR_IRQEN: ctl_d.irq_en  = wr_bit;
                ADR_WAKE:  ctl_d.wake_en = wr_bit;
                ADR_PEND:  if (wr_bit) ctl_d.pend = 1'b0;
                default:   ;
            endcase
        end
        // expiry is applied last so it overrides a same-cycle clear
        if (expire) begin
            ctl_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ctrl = ctl_q;
endmodule

// File: rtl/cd_rdmux.sv
module cd_rdmux
    import alarm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic [ALM_ADDR_W-1:0] rd_addr,
    input  logic [CNT_W-1:0]      count,
    input  ctrl_t                 ctrl,
    output logic [CNT_W-1:0]      rd_data
);
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADR_COUNT: rd_data    = count;
            ADR_RUN:   rd_data[0] = ctrl.run;
            ADR_IRQEN: rd_data[0] = ctrl.irq_en;
            ADR_PEND:  rd_data[0] = ctrl.pend;
            ADR_WAKE:  rd_data[0] = ctrl.wake_en;
            default:   rd_data    = '0;
        endcase
    end
endmodule

// File: rtl/cd_alarm.sv
module cd_alarm
    import alarm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  wr_en,
    input  logic [ALM_ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]      wr_data,
    input  logic [ALM_ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]      rd_data,
    output logic                  irq,
    output logic                  wake
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] cnt_val;
    logic             expire;
    logic             ld_cnt;

    assign ld_cnt = wr_en && (wr_addr == ADR_COUNT);

    cd_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .run    (ctrl.run),
        .ld     (ld_cnt),
        .ld_val (wr_data),
        .count  (cnt_val),
        .expire (expire)
    );

    cd_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_bit  (wr_data[0]),
        .expire  (expire),
        .ctrl    (ctrl)
    );

    cd_rdmux #(.CNT_W(CNT_W)) u_rd (
        .rd_addr (rd_addr),
        .count   (cnt_val),
        .ctrl    (ctrl),
        .rd_data (rd_data)
    );

    assign irq  = ctrl.pend && ctrl.irq_en;
    assign wake = ctrl.pend && ctrl.wake_en;
endmodule

// File: rtl/cd_alarm_chk.sv
module cd_alarm_chk
    import alarm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  tick,
    input logic                  wr_en,
    input logic [ALM_ADDR_W-1:0] wr_addr,
    input logic [CNT_W-1:0]      wr_data,
    input logic [CNT_W-1:0]      cnt_val,
    input ctrl_t                 ctrl,
    input logic                  irq,
    input logic                  wake
);
    logic ld, clr, fire;
    assign ld   = wr_en && (wr_addr == ADR_COUNT);
    assign clr  = wr_en && (wr_addr == ADR_PEND) && wr_data[0];
    assign fire = ctrl.run && tick && !ld && (cnt_val == CNT_W'(1));

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (cnt_val == $past(wr_data)));

    p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.run && tick && !ld && (cnt_val != '0)) |=> (cnt_val == $past(cnt_val) - CNT_W'(1)));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.run && !ld) |=> $stable(cnt_val));

    p_expire_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (ctrl.pend && (cnt_val == '0)));

    p_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl.pend) |-> ($past(cnt_val) == CNT_W'(1)));

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !fire) |=> !ctrl.pend);

    p_setwins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && fire) |=> ctrl.pend);

    p_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ctrl.pend && ctrl.irq_en));

    p_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (ctrl.pend && ctrl.wake_en));
endmodule

bind cd_alarm cd_alarm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cnt_val (cnt_val),
    .ctrl    (ctrl),
    .irq     (irq),
    .wake    (wake)
);

// File: tb/sim_cd_alarm.sv
`timescale 1ns/1ps
module sim_cd_alarm;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq, wake;

    int tests = 0;
    int fails = 0;

    logic [31:0] m_cnt;
    logic        m_run, m_ie, m_pend, m_wk;

    always #5 clk = ~clk;

    cd_alarm u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq), .wake(wake)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return m_cnt;
            3'd1: return {31'd0, m_run};
            3'd2: return {31'd0, m_ie};
            3'd3: return {31'd0, m_pend};
            3'd4: return {31'd0, m_wk};
            default: return 32'd0;
        endcase
    endfunction

    // advance model by one edge using the inputs applied during the cycle
    function automatic void model_step(input logic t, input logic we,
                                       input logic [2:0] a, input logic [31:0] d);
        logic wc, ex, cl;
        wc = we && (a == 3'd0);
        ex = m_run && t && (m_cnt == 32'd1) && !wc;
        cl = we && (a == 3'd3) && d[0];
        if (wc) m_cnt = d;
        else if (m_run && t && m_cnt != 0) m_cnt = m_cnt - 1;
        if (we && a == 3'd1) m_run = d[0];
        if (we && a == 3'd2) m_ie = d[0];
        if (we && a == 3'd4) m_wk = d[0];
        if (ex) m_pend = 1'b1;
        else if (cl) m_pend = 1'b0;
    endfunction

    // one clock: drive at negedge, update model after posedge
    task automatic cyc(input logic t, input logic we, input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        tick = t; wr_en = we; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1;
        model_step(t, we, a, d);
        tick = 1'b0; wr_en = 1'b0;
    endtask

    task automatic check_all(input string tag);
        for (int a = 0; a < 8; a++) begin
            rd_addr = 3'(a);
            #0.5;
            check($sformatf("%s R10 addr%0d", tag, a), rd_data, model_read(3'(a)));
        end
        check({tag, " R8 irq"}, {31'd0, irq}, {31'd0, m_pend & m_ie});
        check({tag, " R9 wake"}, {31'd0, wake}, {31'd0, m_pend & m_wk});
    endtask

    task automatic rd(input string req, input logic [2:0] a, input logic [31:0] exp);
        rd_addr = a;
        #0.5;
        check(req, rd_data, exp);
    endtask

    initial begin
        m_cnt = 0; m_run = 0; m_ie = 0; m_pend = 0; m_wk = 0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        check_all("R1 reset");
        @(negedge clk);
        rst_n = 1'b1;

        // R2: full-width load, R3: decrement across width
        cyc(0, 1, 3'd0, 32'hFFFF_FFFF);
        rd("R2 load", 3'd0, 32'hFFFF_FFFF);
        cyc(1, 0, 0, 0);
        rd("R3 frozen while stopped", 3'd0, 32'hFFFF_FFFF);
        cyc(0, 1, 3'd1, 32'hFFFF_FFFF);
        rd("R10 upper bits read 0", 3'd1, 32'd1);
        cyc(1, 0, 0, 0);
        rd("R3 decrement", 3'd0, 32'hFFFF_FFFE);
        cyc(0, 0, 0, 0);
        rd("R3 no tick no change", 3'd0, 32'hFFFF_FFFE);
        // R2: write wins over tick
        cyc(1, 1, 3'd0, 32'd3);
        rd("R2 write beats tick", 3'd0, 32'd3);
        // R4: run to expiry, interrupt and wakeup enabled
        cyc(0, 1, 3'd2, 32'd1);
        cyc(0, 1, 3'd4, 32'd1);
        cyc(1, 0, 0, 0);
        cyc(1, 0, 0, 0);
        rd("R4 not yet pending", 3'd3, 32'd0);
        check("R8 irq low before expiry", {31'd0, irq}, 32'd0);
        cyc(1, 0, 0, 0);
        rd("R4 pending at 1->0", 3'd3, 32'd1);
        rd("R4 count 0", 3'd0, 32'd0);
        check("R8 irq high", {31'd0, irq}, 32'd1);
        check("R9 wake high", {31'd0, wake}, 32'd1);
        cyc(1, 0, 0, 0);
        rd("R4 count stays 0", 3'd0, 32'd0);
        // R6: write 0 no effect, write 1 clears
        cyc(0, 1, 3'd3, 32'd0);
        rd("R6 write 0 keeps pending", 3'd3, 32'd1);
        cyc(0, 1, 3'd3, 32'd1);
        rd("R6 W1C clears", 3'd3, 32'd0);
        check("R8 irq drops", {31'd0, irq}, 32'd0);
        // R5: ticks at 0 with run set
        repeat (4) cyc(1, 0, 0, 0);
        rd("R5 no pending from zero", 3'd3, 32'd0);
        // R7: clear and expiry same cycle
        cyc(0, 1, 3'd0, 32'd1);
        cyc(1, 1, 3'd3, 32'd1);
        rd("R7 set wins", 3'd3, 32'd1);
        // R8/R9 gating by enables
        cyc(0, 1, 3'd2, 32'd0);
        check("R8 irq gated", {31'd0, irq}, 32'd0);
        check("R9 wake still on", {31'd0, wake}, 32'd1);
        cyc(0, 1, 3'd4, 32'd0);
        check("R9 wake gated", {31'd0, wake}, 32'd0);
        // R10: unmapped writes change nothing
        cyc(0, 1, 3'd6, 32'hFFFF_FFFF);
        check_all("R10 unmapped write");

        // constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            logic t, we;
            logic [2:0] a;
            logic [31:0] d;
            t  = ($urandom % 2) == 0;
            we = ($urandom % 4) == 0;
            a  = 3'($urandom % 7);
            d  = (a == 3'd0) ? ($urandom % 6) : $urandom;
            cyc(t, we, a, d);
            check_all("rand");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule